// File: doc/BRIEF.md
# Wheel Speed Channel Status Flags

This block keeps the interrupt status of one wheel-speed timer channel. The channel logic around it reports four kinds of event as single-cycle strobes: a time-base capture, an accepted input edge for pulse-width measurement, a wrap of the event counter, and a match between the event counter and its programmed event value. Each strobe sets a sticky flag. A fifth flag records a capture that arrived while an earlier capture had not yet been acknowledged. A masked OR of the four event flags forms the interrupt request.

Software acknowledges a flag in one of two ways. It can write 1 to the flag's bit in the status register. It can also access the data register that belongs to the flag: reading the capture/counter register, reading the pulse-width register, or writing the event-value register. The access path works only while the channel is in wheel-speed mode and the freeze input is low. A strobe that arrives in the same cycle as a clear of its own flag always wins.

A small state machine follows the mode input. It has three states. `ARM_OFF` means the channel is disabled and event strobes are ignored. `ARM_WAIT` means the channel has just been enabled and the next capture is dropped, because the two capture registers may not yet agree. `ARM_LIVE` is normal operation. The transitions are:
- OFF_TO_WAIT: from `ARM_OFF` when mode is high.
- WAIT_TO_LIVE: from `ARM_WAIT` on a capture strobe.
- ANY_TO_OFF: from any state when mode is low. This transition has priority over the others.

Top module: `wss_flag_unit`

## Requirements
- R1: A synchronous reset clears all five flags, clears the interrupt request and returns the state machine to `ARM_OFF`.
- R2: In `ARM_LIVE`, a capture strobe sets the capture flag at the next clock edge. The one capture strobe consumed in `ARM_WAIT` sets no flag.
- R3: In `ARM_WAIT` or `ARM_LIVE`, the edge, wrap and match strobes each set their own flag at the next clock edge. In `ARM_OFF`, all four strobes are ignored.
- R4: A status write uses these bit positions: bit 0 clears capture, bit 1 clears edge, bit 2 clears wrap, bit 3 clears match, bit 4 clears overrun. Bits written as 0 leave their flags unchanged. A status write takes effect in any mode.
- R5: Register accesses clear flags only while mode is high and freeze is low. A capture/counter read clears the capture and wrap flags. A pulse-width read clears the edge flag. An event-value write clears the match flag.
- R6: A setting strobe and a clear of the same flag in the same cycle leave the flag set.
- R7: The overrun flag sets when a flag-setting capture meets a capture flag that is already set and is not being cleared in that cycle. A coincident clear of the capture flag prevents the overrun. Status bit 4 clears the overrun flag, and a coincident overrun condition wins over that clear.
- R8: The interrupt request is the OR of the capture, edge, wrap and match flags, each ANDed with its enable bit. The enable bits are irq_en[0] for capture, [1] for edge, [2] for wrap and [3] for match. The overrun flag does not drive the request.
- R9: The state machine follows OFF_TO_WAIT, WAIT_TO_LIVE and ANY_TO_OFF. Each new entry into wheel-speed mode drops its first capture again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_on | input | 1 | Channel is in wheel-speed mode |
| freeze | input | 1 | Debug freeze; blocks clearing by register access |
| evt_cap | input | 1 | Time-base capture strobe |
| evt_edge | input | 1 | Accepted input edge strobe |
| evt_wrap | input | 1 | Event counter wrap strobe |
| evt_match | input | 1 | Event counter equals event value strobe |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 5 | Write-1-to-clear data, one bit per flag |
| rd_capcnt | input | 1 | Capture/counter register read strobe |
| rd_width | input | 1 | Pulse-width register read strobe |
| wr_evval | input | 1 | Event-value register write strobe |
| irq_en | input | 4 | Interrupt enables for capture, edge, wrap, match |
| flag_cap | output | 1 | Capture flag |
| flag_edge | output | 1 | Edge flag |
| flag_wrap | output | 1 | Counter wrap flag |
| flag_match | output | 1 | Compare match flag |
| flag_ovr | output | 1 | Capture overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Every flag is a register whose value appears directly on a port, so a wrong set or clear decision shows one clock edge after the strobe or access that caused it. The interrupt request follows in the same cycle as the flag. A state machine left in the wrong state is not visible directly. It shows up later, at the next capture strobe: that capture either sets the flag when it should have been dropped, or is dropped when it should have set the flag. For this reason the sequences toggle the mode and then apply two captures in a row. Overrun errors show one cycle after a second capture, and only when the clear-coincidence cases are driven, so those cases are covered explicitly.

// File: rtl/wss_pkg.sv
package wss_pkg;
    localparam int NUM_EVT   = 4;
    localparam int NUM_FLAGS = NUM_EVT + 1;

    localparam int FL_CAP   = 0;
    localparam int FL_EDGE  = 1;
    localparam int FL_WRAP  = 2;
    localparam int FL_MATCH = 3;
    localparam int FL_OVR   = 4;

    typedef enum logic [1:0] {
        ARM_OFF  = 2'd0,
        ARM_WAIT = 2'd1,
        ARM_LIVE = 2'd2
    } arm_state_e;
endpackage

// File: rtl/wss_arm_fsm.sv
module wss_arm_fsm
    import wss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_on,
    input  logic       cap_evt,
    output arm_state_e state,
    output logic       evt_ok,
    output logic       cap_take
);
    arm_state_e nxt;

    // next-state logic: ANY_TO_OFF has priority
    always_comb begin
        nxt = state;
        unique case (state)
            ARM_OFF:  nxt = mode_on ? ARM_WAIT : ARM_OFF;           // OFF_TO_WAIT
            ARM_WAIT: begin
                if (!mode_on)     nxt = ARM_OFF;                    // ANY_TO_OFF
                else if (cap_evt) nxt = ARM_LIVE;                   // WAIT_TO_LIVE
                else              nxt = ARM_WAIT;
            end
            ARM_LIVE: nxt = mode_on ? ARM_LIVE : ARM_OFF;           // ANY_TO_OFF
            default:  nxt = ARM_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ARM_OFF;
        else     state <= nxt;
    end

    // outputs per state
    always_comb begin
        evt_ok   = 1'b0;
        cap_take = 1'b0;
        unique case (state)
            ARM_OFF:  begin evt_ok = 1'b0; cap_take = 1'b0; end
            ARM_WAIT: begin evt_ok = 1'b1; cap_take = 1'b0; end
            ARM_LIVE: begin evt_ok = 1'b1; cap_take = 1'b1; end
            default:  begin evt_ok = 1'b0; cap_take = 1'b0; end
        endcase
    end

    assert_leave_on_mode_low_R9: assert property (@(posedge clk) disable iff (rst)
        !mode_on |=> state == ARM_OFF);
    assert_wait_to_live_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ARM_WAIT && mode_on && cap_evt) |=> state == ARM_LIVE);
    assert_off_to_wait_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ARM_OFF && mode_on) |=> state == ARM_WAIT);
endmodule

// File: rtl/wss_clear_dec.sv
module wss_clear_dec
    import wss_pkg::*;
(
    input  logic                 mode_on,
    input  logic                 freeze,
    input  logic                 sts_wr,
    input  logic [NUM_FLAGS-1:0] sts_wdata,
    input  logic                 rd_capcnt,
    input  logic                 rd_width,
    input  logic                 wr_evval,
    output logic [NUM_FLAGS-1:0] clr
);
    logic acc_ok;
    logic [NUM_FLAGS-1:0] w1c;
    logic [NUM_FLAGS-1:0] side;

    always_comb begin
        acc_ok          = mode_on & ~freeze;
        w1c             = sts_wdata & {NUM_FLAGS{sts_wr}};
        side            = '0;
        side[FL_CAP]    = rd_capcnt & acc_ok;
        side[FL_WRAP]   = rd_capcnt & acc_ok;
        side[FL_EDGE]   = rd_width  & acc_ok;
        side[FL_MATCH]  = wr_evval  & acc_ok;
        clr             = w1c | side;
    end
endmodule

// File: rtl/wss_flag_cell.sv
module wss_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
endmodule

// File: rtl/wss_irq_merge.sv
module wss_irq_merge #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] en,
    output logic             irq
);
    logic [WIDTH-1:0] hit;

    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign hit[g] = flags[g] & en[g];
    end

    assign irq = |hit;
endmodule

// File: rtl/wss_flag_unit.sv
module wss_flag_unit
    import wss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_on,
    input  logic                 freeze,
    input  logic                 evt_cap,
    input  logic                 evt_edge,
    input  logic                 evt_wrap,
    input  logic                 evt_match,
    input  logic                 sts_wr,
    input  logic [NUM_FLAGS-1:0] sts_wdata,
    input  logic                 rd_capcnt,
    input  logic                 rd_width,
    input  logic                 wr_evval,
    input  logic [NUM_EVT-1:0]   irq_en,
    output logic                 flag_cap,
    output logic                 flag_edge,
    output logic                 flag_wrap,
    output logic                 flag_match,
    output logic                 flag_ovr,
    output logic                 irq
);
    arm_state_e           arm_state;
    logic                 evt_ok;
    logic                 cap_take;
    logic [NUM_FLAGS-1:0] clr;
    logic [NUM_FLAGS-1:0] set;
    logic [NUM_FLAGS-1:0] q;
    logic [NUM_EVT-1:0]   strobes;

    wss_arm_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mode_on  (mode_on),
        .cap_evt  (evt_cap),
        .state    (arm_state),
        .evt_ok   (evt_ok),
        .cap_take (cap_take)
    );

    wss_clear_dec u_clr (
        .mode_on   (mode_on),
        .freeze    (freeze),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .rd_capcnt (rd_capcnt),
        .rd_width  (rd_width),
        .wr_evval  (wr_evval),
        .clr       (clr)
    );

    always_comb begin
        strobes           = '0;
        strobes[FL_CAP]   = evt_cap;
        strobes[FL_EDGE]  = evt_edge;
        strobes[FL_WRAP]  = evt_wrap;
        strobes[FL_MATCH] = evt_match;

        set               = '0;
        set[NUM_EVT-1:0]  = strobes & {NUM_EVT{evt_ok}};
        set[FL_CAP]       = evt_cap & cap_take;
        // overrun: accepted capture on an unacknowledged flag with no clear
        set[FL_OVR]       = set[FL_CAP] & q[FL_CAP] & ~clr[FL_CAP];
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        wss_flag_cell u_cell (
            .clk (clk),
            .rst (rst),
            .set (set[g]),
            .clr (clr[g]),
            .q   (q[g])
        );
    end

    wss_irq_merge #(.WIDTH(NUM_EVT)) u_irq (
        .flags (q[NUM_EVT-1:0]),
        .en    (irq_en),
        .irq   (irq)
    );

    assign flag_cap   = q[FL_CAP];
    assign flag_edge  = q[FL_EDGE];
    assign flag_wrap  = q[FL_WRAP];
    assign flag_match = q[FL_MATCH];
    assign flag_ovr   = q[FL_OVR];

    assert_first_capture_dropped_R2: assert property (@(posedge clk) disable iff (rst)
        (arm_state == ARM_WAIT && !flag_cap) |=> !flag_cap);
    assert_off_ignores_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (arm_state == ARM_OFF && !flag_edge) |=> !flag_edge);
    assert_freeze_blocks_access_R5: assert property (@(posedge clk) disable iff (rst)
        (freeze && !sts_wr && flag_edge) |=> flag_edge);
    assert_no_ovr_on_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr[FL_CAP] && !flag_ovr) |=> !flag_ovr);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q == '0 && !irq));
endmodule

// File: tb/wss_flag_unit_bench.sv
`timescale 1ns/1ps
module wss_flag_unit_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_on, freeze;
    logic       evt_cap, evt_edge, evt_wrap, evt_match;
    logic       sts_wr;
    logic [4:0] sts_wdata;
    logic       rd_capcnt, rd_width, wr_evval;
    logic [3:0] irq_en;
    logic       flag_cap, flag_edge, flag_wrap, flag_match, flag_ovr, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    wss_flag_unit u_wss_flag_unit (
        .clk(clk), .rst(rst), .mode_on(mode_on), .freeze(freeze),
        .evt_cap(evt_cap), .evt_edge(evt_edge), .evt_wrap(evt_wrap), .evt_match(evt_match),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .rd_capcnt(rd_capcnt),
        .rd_width(rd_width), .wr_evval(wr_evval), .irq_en(irq_en),
        .flag_cap(flag_cap), .flag_edge(flag_edge), .flag_wrap(flag_wrap),
        .flag_match(flag_match), .flag_ovr(flag_ovr), .irq(irq)
    );

    // vector: {mode, frz, ev[3:0]=match,wrap,edge,cap, wr, wd[4:0], rc, rw, we, en[3:0], exp[4:0]=ovr,match,wrap,edge,cap, irq}
    localparam int NV = 27;
    localparam logic [24:0] TBL [0:NV-1] = '{
        {1'b1,1'b0,4'b0000,1'b0,5'b00000,3'b000,4'b0000,5'b00000,1'b0}, //  0 R9 enter wait
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b000,4'b0000,5'b00000,1'b0}, //  1 R2 first capture dropped
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b000,4'b0001,5'b00001,1'b1}, //  2 R2 R8
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b000,4'b0000,5'b10001,1'b0}, //  3 R7 overrun
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b100,4'b0000,5'b10001,1'b0}, //  4 R6 read+capture
        {1'b1,1'b0,4'b0000,1'b1,5'b10000,3'b000,4'b0000,5'b00001,1'b0}, //  5 R7 clear ovr
        {1'b1,1'b0,4'b0000,1'b0,5'b00000,3'b100,4'b0000,5'b00000,1'b0}, //  6 R5 read clears cap
        {1'b1,1'b0,4'b1110,1'b0,5'b00000,3'b000,4'b1000,5'b01110,1'b1}, //  7 R3 R8
        {1'b1,1'b1,4'b0000,1'b0,5'b00000,3'b111,4'b0000,5'b01110,1'b0}, //  8 R5 freeze
        {1'b1,1'b0,4'b0000,1'b0,5'b00000,3'b010,4'b0000,5'b01100,1'b0}, //  9 R5 width read
        {1'b1,1'b0,4'b0000,1'b0,5'b00000,3'b100,4'b0000,5'b01000,1'b0}, // 10 R5 wrap by read
        {1'b1,1'b0,4'b1000,1'b0,5'b00000,3'b001,4'b0000,5'b01000,1'b0}, // 11 R6 match wins
        {1'b1,1'b0,4'b0000,1'b0,5'b00000,3'b001,4'b0000,5'b00000,1'b0}, // 12 R5 evval write
        {1'b1,1'b0,4'b0010,1'b1,5'b00010,3'b000,4'b0000,5'b00010,1'b0}, // 13 R6 edge wins
        {1'b1,1'b0,4'b0000,1'b1,5'b11101,3'b000,4'b0010,5'b00010,1'b1}, // 14 R4 zero bit keeps
        {1'b1,1'b0,4'b0000,1'b1,5'b00010,3'b000,4'b0000,5'b00000,1'b0}, // 15 R4
        {1'b1,1'b0,4'b0010,1'b0,5'b00000,3'b000,4'b0000,5'b00010,1'b0}, // 16 R3
        {1'b0,1'b0,4'b0000,1'b0,5'b00000,3'b010,4'b0000,5'b00010,1'b0}, // 17 R5 mode low blocks
        {1'b0,1'b0,4'b1111,1'b0,5'b00000,3'b000,4'b0000,5'b00010,1'b0}, // 18 R3 R9 off ignores
        {1'b0,1'b0,4'b0000,1'b1,5'b00010,3'b000,4'b0000,5'b00000,1'b0}, // 19 R4 any mode
        {1'b1,1'b0,4'b0000,1'b0,5'b00000,3'b000,4'b0000,5'b00000,1'b0}, // 20 R9 re-enter
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b000,4'b0000,5'b00000,1'b0}, // 21 R2 dropped again
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b000,4'b0000,5'b00001,1'b0}, // 22 R2
        {1'b1,1'b0,4'b0001,1'b1,5'b00001,3'b000,4'b0000,5'b00001,1'b0}, // 23 R7 clear blocks ovr
        {1'b1,1'b0,4'b0001,1'b0,5'b00000,3'b000,4'b0000,5'b10001,1'b0}, // 24 R7
        {1'b1,1'b0,4'b0001,1'b1,5'b10000,3'b000,4'b0000,5'b10001,1'b0}, // 25 R7 ovr set wins
        {1'b1,1'b0,4'b0000,1'b1,5'b10001,3'b000,4'b1111,5'b00000,1'b0}  // 26 R8 all clear
    };
    localparam int VREQ [0:NV-1] = '{9,2,2,7,6,7,5,3,5,5,5,6,5,6,4,4,3,5,3,4,9,2,2,7,7,7,8};

    function automatic logic [5:0] outs();
        return {flag_ovr, flag_match, flag_wrap, flag_edge, flag_cap, irq};
    endfunction

    task automatic chk(input int req, input string what, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic idle();
        {evt_cap, evt_edge, evt_wrap, evt_match} = '0;
        sts_wr = 0; sts_wdata = '0; rd_capcnt = 0; rd_width = 0; wr_evval = 0;
        freeze = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        rst = 1; mode_on = 0; irq_en = '0; idle();
        repeat (3) @(negedge clk);
        chk(1, "reset state R1", outs(), 6'b0);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = TBL[i];
            mode_on = v[24]; freeze = v[23];
            {evt_match, evt_wrap, evt_edge, evt_cap} = v[22:19];
            sts_wr = v[18]; sts_wdata = v[17:13];
            {rd_capcnt, rd_width, wr_evval} = v[12:10];
            irq_en = v[9:6];
            @(negedge clk);
            chk(VREQ[i], $sformatf("vector %0d", i), outs(), v[5:0]);
        end
        // directed: reset mid-operation clears everything (R1)
        idle(); mode_on = 1; evt_cap = 1; evt_edge = 1; irq_en = 4'b1111;
        @(negedge clk);
        chk(3, "edge set before reset R3", outs(), 6'b000111);
        idle(); rst = 1;
        @(negedge clk);
        chk(1, "mid-run reset R1", outs(), 6'b0);
        rst = 0;
        @(negedge clk);               // OFF -> WAIT
        evt_cap = 1;
        @(negedge clk);               // dropped in WAIT
        chk(2, "first capture after reset R2", outs(), 6'b0);
        @(negedge clk);               // LIVE: flagged
        chk(2, "second capture after reset R2", outs(), 6'b000011);
        // freeze blocks capture read but status write still clears (R5, R4)
        idle(); freeze = 1; rd_capcnt = 1;
        @(negedge clk);
        chk(5, "freeze blocks read clear R5", outs(), 6'b000011);
        idle(); freeze = 1; sts_wr = 1; sts_wdata = 5'b00001;
        @(negedge clk);
        chk(4, "status write under freeze R4", outs(), 6'b0);
        idle();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule